// File: doc/BRIEF.md
# Framed Serial Converter Host Port

This block is the host side of a framed serial link to a multi-channel analog-to-digital converter. One request from the user logic runs a full acquisition. The block first sends a control word that selects the channel and the output format. It then raises a convert-start pulse and waits for the converter's end-of-conversion strobe. Finally it clocks the conversion result back in. Two separate active-low frame syncs mark the two transfer directions. One frames the control word, which goes out on the converter's data-in line. The other frames the result, which comes back on the converter's data-out line.

The serial clock is made from the system clock by dividing it down. Each high or low phase lasts `DIV_HALF` system cycles. `DIV_HALF` must be at least 2, and large enough that a phase is at least 25 ns long (the default of 3 gives 30 ns at 100 MHz). The clock idles high. The host changes its outgoing bit in the same cycle that the serial clock rises. It samples the incoming bit in the same cycle that the serial clock falls. A frame sync goes low one whole phase before the first falling edge. It returns high one whole phase after the last falling edge.

The state machine has nine states:

- `S_IDLE`: the link is quiet. A start request moves to `S_WR_LEAD`.
- `S_WR_LEAD`: the transmit sync is low and the clock is high. A phase tick moves to `S_WR_LOW`.
- `S_WR_LOW`: the clock is low. A phase tick moves to `S_WR_HIGH`, or to `S_CONV` after the last control bit.
- `S_WR_HIGH`: the clock is high. A phase tick moves back to `S_WR_LOW`.
- `S_CONV`: the convert-start pulse is high. After `CONV_CYC` cycles it moves to `S_EOC_WAIT`.
- `S_EOC_WAIT`: the block waits. A low level on `eoc_n` moves to `S_RD_LEAD`.
- `S_RD_LEAD`: the receive sync is low and the clock is high. A phase tick moves to `S_RD_LOW`.
- `S_RD_LOW`: the clock is low. A phase tick moves to `S_RD_HIGH`, or back to `S_IDLE` after the last result bit.
- `S_RD_HIGH`: the clock is high. A phase tick moves back to `S_RD_LOW`.

Top module: `adc_serial_host`

## Requirements
- R1: While reset is applied and right after it: `sclk`=1, `tfs_n`=1, `rfs_n`=1, `convst`=0, `done`=0, `result`=0.
- R2: A start request in idle sends one control frame of exactly CH_BITS+3 bits, MSB first, while `tfs_n` is low. The word, from MSB to LSB, is `{chan[CH_BITS-1:0], 0 (software convert off), 0 (software standby off), fmt}`. The converter takes each bit on a falling edge of `sclk`.
- R3: Every high and low phase of `sclk` inside a frame lasts DIV_HALF cycles. A frame sync falls DIV_HALF cycles before the first falling edge of `sclk`. `din` changes only while `sclk` is high or in the cycle where `sclk` rises, so it is steady for the whole low phase.
- R4: After the control frame, `convst` goes high exactly once for CONV_CYC cycles. Both frame syncs stay high and `sclk` stays high during the pulse.
- R5: After the pulse the block waits for `eoc_n` to go low. Until then `rfs_n` and `sclk` stay high, with no time limit.
- R6: Once `eoc_n` is seen low, `rfs_n` goes low for exactly RES_BITS falling edges of `sclk`. `dout` is captured on each falling edge, MSB first.
- R7: `done` is a one-cycle pulse. It comes one cycle after the last bit is captured, while `sclk` is still low. In the same cycle `result` takes the captured word, and it holds that value until the next `done`.
- R8: A start request is ignored whenever the block is not idle, including the cycle in which `done` is high.
- R9: The two frame syncs are never low at the same time. While both are high, `sclk` is high.
- R10: If `start` is held high, a new acquisition begins as soon as the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one acquisition (sampled in idle) |
| chan | input | CH_BITS | Channel number for the control word |
| fmt | input | 1 | Output format flag for the control word |
| sclk | output | 1 | Serial clock, idles high |
| tfs_n | output | 1 | Transmit frame sync, active low |
| din | output | 1 | Serial control data to the converter |
| rfs_n | output | 1 | Receive frame sync, active low |
| dout | input | 1 | Serial result data from the converter |
| convst | output | 1 | Convert-start pulse, active high |
| eoc_n | input | 1 | End of conversion from the converter, active low |
| result | output | RES_BITS | Last received conversion result |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can land in the same cycle: the `done` pulse and a new start request. The `done` pulse is issued while the final low phase of `sclk` is still running. The bench drives a one-cycle start in exactly the cycle it sees `done` high. It then counts transmit frames and checks that no second frame opens. A second case holds `start` high through completion, and there exactly one follow-on frame must open once the block is idle again.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

    // Controller phases; frame states keep the serial clock generator running
    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_LEAD,
        S_WR_LOW,
        S_WR_HIGH,
        S_CONV,
        S_EOC_WAIT,
        S_RD_LEAD,
        S_RD_LOW,
        S_RD_HIGH
    } ser_state_t;

    // Fixed flag bits inside the control word: hardware convert start, no standby
    localparam logic SW_CONV_FLAG = 1'b0;
    localparam logic SW_STBY_FLAG = 1'b0;

endpackage

// File: rtl/adc_ser_clkdiv.sv
module adc_ser_clkdiv #(
    parameter int DIV_HALF = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic half_tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;

    assign half_tick = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !en || half_tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_ser_shreg.sv
module adc_ser_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    input  logic             sin,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {q[WIDTH-2:0], sin};
        end
    end
endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
    import adc_ser_pkg::*;
#(
    parameter int CH_BITS  = 3,
    parameter int RES_BITS = 12,
    parameter int DIV_HALF = 3,
    parameter int CONV_CYC = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CH_BITS-1:0]  chan,
    input  logic                fmt,
    output logic                sclk,
    output logic                tfs_n,
    output logic                din,
    output logic                rfs_n,
    input  logic                dout,
    output logic                convst,
    input  logic                eoc_n,
    output logic [RES_BITS-1:0] result,
    output logic                done
);
    localparam int CTRL_BITS = CH_BITS + 3;
    localparam int MAX_BITS  = (CTRL_BITS > RES_BITS) ? CTRL_BITS : RES_BITS;
    localparam int BCW       = $clog2(MAX_BITS);
    localparam int PCW       = $clog2(CONV_CYC + 1);
    localparam logic [BCW-1:0] WR_LAST_IDX = BCW'(CTRL_BITS - 1);
    localparam logic [BCW-1:0] RD_LAST_IDX = BCW'(RES_BITS - 1);
    localparam logic [PCW-1:0] PULSE_LAST  = PCW'(CONV_CYC - 1);

    ser_state_t            state, nxt;
    logic                  tick, run_clk;
    logic [BCW-1:0]        bit_cnt;
    logic [PCW-1:0]        pul_cnt;
    logic                  wr_last, rd_last;
    logic                  ctl_load, ctl_shift, rx_shift, last_cap, last_q;
    logic [CTRL_BITS-1:0]  tx_q;
    logic [RES_BITS-1:0]   rx_q;

    assign wr_last   = (bit_cnt == WR_LAST_IDX);
    assign rd_last   = (bit_cnt == RD_LAST_IDX);
    assign ctl_load  = (state == S_IDLE) && start;
    assign ctl_shift = (state == S_WR_LOW) && tick && !wr_last;
    assign rx_shift  = tick && ((state == S_RD_LEAD) || (state == S_RD_HIGH));
    assign last_cap  = (state == S_RD_HIGH) && tick && rd_last;
    assign din       = tx_q[CTRL_BITS-1];

    adc_ser_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
        .clk(clk), .rst_n(rst_n), .en(run_clk), .half_tick(tick)
    );

    adc_ser_shreg #(.WIDTH(CTRL_BITS)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(ctl_load),
        .load_val({chan, SW_CONV_FLAG, SW_STBY_FLAG, fmt}),
        .shift(ctl_shift), .sin(1'b0), .q(tx_q)
    );

    adc_ser_shreg #(.WIDTH(RES_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0),
        .shift(rx_shift), .sin(dout), .q(rx_q)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Transition logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (start) nxt = S_WR_LEAD;
            S_WR_LEAD:  if (tick) nxt = S_WR_LOW;
            S_WR_LOW:   if (tick) nxt = wr_last ? S_CONV : S_WR_HIGH;
            S_WR_HIGH:  if (tick) nxt = S_WR_LOW;
            S_CONV:     if (pul_cnt == PULSE_LAST) nxt = S_EOC_WAIT;
            S_EOC_WAIT: if (!eoc_n) nxt = S_RD_LEAD;
            S_RD_LEAD:  if (tick) nxt = S_RD_LOW;
            S_RD_LOW:   if (tick) nxt = rd_last ? S_IDLE : S_RD_HIGH;
            S_RD_HIGH:  if (tick) nxt = S_RD_LOW;
            default:    nxt = S_IDLE;
        endcase
    end

    // Moore outputs decoded from the state register
    always_comb begin
        sclk    = 1'b1;
        tfs_n   = 1'b1;
        rfs_n   = 1'b1;
        convst  = 1'b0;
        run_clk = 1'b0;
        unique case (state)
            S_WR_LEAD, S_WR_HIGH: begin tfs_n = 1'b0; run_clk = 1'b1; end
            S_WR_LOW:   begin tfs_n = 1'b0; sclk = 1'b0; run_clk = 1'b1; end
            S_CONV:     convst = 1'b1;
            S_RD_LEAD, S_RD_HIGH: begin rfs_n = 1'b0; run_clk = 1'b1; end
            S_RD_LOW:   begin rfs_n = 1'b0; sclk = 1'b0; run_clk = 1'b1; end
            default:    ;
        endcase
    end

    // Bit and pulse counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            pul_cnt <= '0;
        end else begin
            if (((state == S_WR_LOW) && wr_last) || ((state == S_RD_LOW) && rd_last)) begin
                if (tick) bit_cnt <= '0;
            end else if ((state == S_WR_LOW) || (state == S_RD_LOW)) begin
                if (tick) bit_cnt <= bit_cnt + 1'b1;
            end else if ((state == S_IDLE) || (state == S_EOC_WAIT)) begin
                bit_cnt <= '0;
            end
            pul_cnt <= (state == S_CONV) ? pul_cnt + 1'b1 : '0;
        end
    end

    // Completion: one cycle after the final capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            last_q <= last_cap;
            done   <= last_q;
            if (last_q) result <= rx_q;
        end
    end
endmodule

// File: rtl/adc_serial_host_chk.sv
module adc_serial_host_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic tfs_n,
    input logic rfs_n,
    input logic din,
    input logic convst,
    input logic eoc_n,
    input logic done
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sclk && tfs_n && rfs_n && !convst && !done));

    // R9
    frames_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!tfs_n && !rfs_n));

    // R9
    idle_sclk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tfs_n && rfs_n) |-> sclk);

    // R3
    din_steady_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk && !$past(sclk)) |-> $stable(din));

    // R4
    convst_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        convst |-> (tfs_n && rfs_n && sclk));

    // R5
    rfs_after_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rfs_n) |-> !$past(eoc_n));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rfs_n && !sclk));
endmodule

bind adc_serial_host adc_serial_host_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .tfs_n(tfs_n), .rfs_n(rfs_n),
    .din(din), .convst(convst), .eoc_n(eoc_n), .done(done)
);

// File: tb/adc_serial_host_test.sv
`timescale 1ns/1ps
module adc_serial_host_test;
    localparam int CHB = 3;
    localparam int RES = 12;
    localparam int DIV = 3;
    localparam int CCY = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CHB-1:0] chan = '0;
    logic fmt = 1'b0;
    logic dout = 1'b0;
    logic eoc_n = 1'b1;
    logic sclk, tfs_n, din, rfs_n, convst, done;
    logic [RES-1:0] result;

    int n_chk = 0;
    int n_bad = 0;

    // converter model state
    logic [RES-1:0] model_word = '0;
    logic [CHB+2:0] ctl_seen = '0;
    int idx = -1;
    int conv_lat = 5;
    int ctl_falls = 0, rd_falls = 0, tfs_frames = 0, convst_pulses = 0;
    int lead_cnt = 0, low_run = 0, last_low = 0, conv_high = 0, last_conv_high = 0;
    logic eoc_seen = 1'b0, early_rfs = 1'b0, both_low = 1'b0;

    always #5 clk = ~clk;

    adc_serial_host #(.CH_BITS(CHB), .RES_BITS(RES), .DIV_HALF(DIV), .CONV_CYC(CCY)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .fmt(fmt),
        .sclk(sclk), .tfs_n(tfs_n), .din(din), .rfs_n(rfs_n), .dout(dout),
        .convst(convst), .eoc_n(eoc_n), .result(result), .done(done)
    );

    always @(negedge sclk) begin
        if (!tfs_n) begin
            ctl_seen = {ctl_seen[CHB+1:0], din};
            ctl_falls++;
        end
        if (!rfs_n) rd_falls++;
    end

    always @(negedge tfs_n) tfs_frames++;

    always @(negedge rfs_n) begin
        if (!eoc_seen) early_rfs = 1'b1;
        #2 dout = model_word[RES-1];
        idx = RES - 2;
    end

    always @(posedge sclk) begin
        if (!rfs_n && idx >= 0) begin
            #2 dout = model_word[idx];
            idx--;
        end
    end

    always @(posedge convst) begin
        convst_pulses++;
        eoc_seen = 1'b0;
        repeat (conv_lat) @(posedge clk);
        #1 eoc_n = 1'b0;
        eoc_seen = 1'b1;
        repeat (3) @(posedge clk);
        #1 eoc_n = 1'b1;
    end

    always @(negedge clk) begin
        if (!tfs_n && !rfs_n) both_low = 1'b1;
        if (!sclk) low_run++;
        else begin
            if (low_run != 0) last_low = low_run;
            low_run = 0;
        end
        if (convst) conv_high++;
        else begin
            if (conv_high != 0) last_conv_high = conv_high;
            conv_high = 0;
        end
        if (!tfs_n && sclk && ctl_falls == 0) lead_cnt++;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_model();
        ctl_falls = 0; rd_falls = 0; tfs_frames = 0; convst_pulses = 0;
        lead_cnt = 0; last_low = 0; last_conv_high = 0; early_rfs = 1'b0;
        ctl_seen = '0;
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        while (!done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (!done) check({tag, " done timeout"}, 0, 1);
    endtask

    task automatic pulse_start(input logic [CHB-1:0] c, input logic f);
        @(negedge clk);
        chan = c; fmt = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 sclk in reset", int'(sclk), 1);
        check("R1 tfs_n in reset", int'(tfs_n), 1);
        check("R1 rfs_n in reset", int'(rfs_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 convst after reset", int'(convst), 0);
        check("R1 done after reset", int'(done), 0);
        check("R1 result after reset", int'(result), 0);
    endtask

    // one acquisition; optionally probes the wait for end of conversion
    task automatic t_xfer(input logic [CHB-1:0] c, input logic f,
                          input logic [RES-1:0] w, input int lat, input bit probe);
        int t = 0;
        clear_model();
        model_word = w;
        conv_lat = lat;
        pulse_start(c, f);
        if (probe) begin
            while (convst_pulses == 0 && t < 500) begin @(negedge clk); t++; end
            repeat (CCY + 15) @(negedge clk);
            check("R5 rfs_n held while waiting", int'(rfs_n), 1);
            check("R5 sclk held while waiting", int'(sclk), 1);
            check("R5 no read edges before eoc", rd_falls, 0);
        end
        wait_done("R7");
        check("R7 result on done", int'(result), int'(w));
        @(negedge clk);
        check("R7 done single cycle", int'(done), 0);
        repeat (4) @(negedge clk);
        check("R2 control word", int'(ctl_seen), int'({c, 2'b00, f}));
        check("R2 control bit count", ctl_falls, CHB + 3);
        check("R3 frame lead", lead_cnt, DIV);
        check("R3 low phase", last_low, DIV);
        check("R4 convst count", convst_pulses, 1);
        check("R4 convst width", last_conv_high, CCY);
        check("R6 read edge count", rd_falls, RES);
        check("R5 rfs waited for eoc", int'(early_rfs), 0);
        check("R7 result held", int'(result), int'(w));
    endtask

    // start requests while busy, including the done cycle
    task automatic t_busy_start();
        int t = 0;
        clear_model();
        model_word = 12'h5A3;
        conv_lat = 30;
        pulse_start(3'd2, 1'b0);
        while (convst_pulses == 0 && t < 500) begin @(negedge clk); t++; end
        @(negedge clk);
        chan = 3'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R8");
        chan = 3'd6; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        check("R8 frames after busy starts", tfs_frames, 1);
        check("R8 control word unchanged", int'(ctl_seen), int'({3'd2, 2'b00, 1'b0}));
        check("R8 result", int'(result), 12'h5A3);
    endtask

    task automatic t_back2back();
        clear_model();
        model_word = 12'h0F0;
        conv_lat = 3;
        @(negedge clk);
        chan = 3'd4; fmt = 1'b1; start = 1'b1;
        wait_done("R10 first");
        @(negedge clk);
        wait_done("R10 second");
        start = 1'b0;
        repeat (40) @(negedge clk);
        check("R10 frames with start held", tfs_frames, 2);
        check("R10 convst pulses", convst_pulses, 2);
        check("R10 result", int'(result), 12'h0F0);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_xfer(3'd5, 1'b1, 12'hA5C, 6, 1'b0);
        t_xfer(3'd0, 1'b0, 12'hFFF, 40, 1'b1);
        t_xfer(3'd7, 1'b0, 12'h001, 2, 1'b0);
        t_xfer(3'd1, 1'b1, 12'h800, 9, 1'b0);
        t_busy_start();
        t_back2back();
        check("R9 frame syncs never both low", int'(both_low), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule